// File: doc/BRIEF.md
# Quarter-Wave DDS Sine Core with Inhibit

This block is the digital half of a tone generator. A 21-bit phase accumulator gains a 16-bit tuning word, zero-extended, once every four input clocks. Each update also produces one 8-bit sample for an external DAC. The output frequency is f_clk × tune_word / 2^23, so one step of the tuning word moves the tone by f_clk / 2^23. The nine top accumulator bits are the phase. They address a single-quadrant table of 128 seven-bit magnitudes. The table address is mirrored in the second and fourth quarters, and the magnitude is complemented in the negative half. This gives a 512-point cycle.

Two level requests come from the serial loader. A power-down request forces the sample to the zero code from the next clock onward. An inhibit request lets the half cycle in progress run to its end, so the output comes to rest at the zero code without a step. The accumulator is then cleared and held. When the request goes away, the tone restarts from phase zero.

Top module: `dds_sine_core`

## Requirements
- R1: `dac_valid` pulses high for exactly one clock on every fourth clock. The first pulse follows the fourth rising edge after reset is released.
- R2: At each update the accumulator becomes (acc + tune_word) mod 2^21, with the tune word zero-extended.
- R3: The sample made at an update comes from the accumulator value before that update. Bit 20 is the sign, bit 19 is the quadrant and bits 18:12 are the index. With the quadrant bit set, the table address is the bitwise inverse of the index.
- R4: Table entry k holds round(127·sin((k+0.5)·π/256)). Phase 0 gives code 0x01, and phase index 127 in quarter 0 gives 0x7F.
- R5: Code bit 7 equals the sign bit. For sign 0, bits 6:0 are the table magnitude. For sign 1, bits 6:0 are its bitwise inverse, so phase 256 gives 0xFE and phase 383 gives 0x80.
- R6: `dac_code` changes only on the clock that raises `dac_valid`, except when R9 applies.
- R7: An update that sees `inh_req` high while running latches the current sign bit, and output continues normally. At the first later update where `inh_req` is still high and the sign bit differs from the latched one, the code becomes 0x00 and the accumulator is cleared.
- R8: While inhibited, every update gives 0x00 and keeps the accumulator at zero. The first update after `inh_req` falls gives the phase-0 code 0x01.
- R9: Every clock that samples `pdn_req` high sets `dac_code` to 0x00. The accumulator and inhibit sequencing keep running underneath.
- R10: During reset and directly after it, `dac_code` is 0x00 and `dac_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| tune_word | input | 16 | Phase increment per update |
| pdn_req | input | 1 | Power-down request, forces the zero code |
| inh_req | input | 1 | Inhibit request, stops at the next half-cycle end |
| dac_code | output | 8 | Sign-plus-magnitude sample |
| dac_valid | output | 1 | One-clock strobe with each new sample |

## Verification
The sweep uses a tuning word of 4096, which steps the phase by exactly one table point per update. This walks all 512 phases in order and exposes a wrong quadrant mirror, a wrong sign complement or a wrong table entry at the named points. Random tuning words, held for hundreds of clocks, exercise accumulator wraparound and the dropped low bits. A large directed step is used to inhibit mid-half-cycle, which separates a correct zero-crossing deferral from an immediate or late stop. A restart check then shows whether the accumulator was cleared. Power-down pulses placed between strobes separate immediate forcing from forcing that waits for an update.

// File: rtl/dds_pkg.sv
package dds_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_HOLD  = 2'd2
  } inh_state_e;

  // Quarter-wave magnitude for table slot k: round(A*sin((k+0.5)*pi/(2*N))),
  // evaluated with a fixed-point Taylor series (Q28) at elaboration time.
  function automatic int quarter_val(int k, int idx_w, int mag_w);
    longint pi_q;
    longint x;
    longint x2;
    longint term;
    longint sum;
    longint amp;
    pi_q = 64'd843314857;
    x    = (longint'(2 * k + 1) * pi_q) / (longint'(4) << idx_w);
    x2   = (x * x) >>> 28;
    term = x;
    sum  = x;
    for (int n = 1; n <= 7; n++) begin
      term = -((term * x2) >>> 28) / longint'((2 * n) * (2 * n + 1));
      sum  = sum + term;
    end
    amp = (longint'(1) << mag_w) - 1;
    return int'((amp * sum + (longint'(1) << 27)) >>> 28);
  endfunction

endpackage

// File: rtl/dds_rate_div.sv
module dds_rate_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_cnt
      localparam int CNT_W = $clog2(DIV);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
      end

      assign tick = (cnt == LAST);

      // R1
      tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int TW_W  = 16,
  parameter int ACC_W = 21,
  parameter int PH_W  = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic            clr,
  input  logic [TW_W-1:0] tw,
  output logic [PH_W-1:0] phase
);

  logic [ACC_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (adv)   acc <= acc + ACC_W'(tw);
  end

  assign phase = acc[ACC_W-1 -: PH_W];

  // R2
  acc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(acc));

endmodule

// File: rtl/dds_quarter_rom.sv
module dds_quarter_rom #(
  parameter int IDX_W = 7,
  parameter int MAG_W = 7
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] addr,
  output logic [MAG_W-1:0] q
);

  localparam int DEPTH = 1 << IDX_W;

  logic [MAG_W-1:0] table_w [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_tab
    localparam int VAL = dds_pkg::quarter_val(k, IDX_W, MAG_W);
    assign table_w[k] = MAG_W'(VAL);
  end

  always_ff @(posedge clk) begin
    q <= table_w[addr];
  end

endmodule

// File: rtl/dds_sine_core.sv
module dds_sine_core #(
  parameter int TW_W  = 16,
  parameter int ACC_W = 21,
  parameter int IDX_W = 7,
  parameter int DIV   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TW_W-1:0]   tune_word,
  input  logic              pdn_req,
  input  logic              inh_req,
  output logic [IDX_W:0]    dac_code,
  output logic              dac_valid
);
  import dds_pkg::*;

  localparam int MAG_W  = IDX_W;
  localparam int PH_W   = IDX_W + 2;
  localparam int CODE_W = IDX_W + 1;

  logic             tick;
  logic [PH_W-1:0]  phase;
  logic             sign_b;
  logic             quad_b;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] rom_addr;
  logic [MAG_W-1:0] rom_q;
  logic [CODE_W-1:0] live_code;

  inh_state_e st, st_nxt;
  logic       dsign;
  logic       acc_adv, acc_clr, force_zero, cap_sign;

  dds_rate_div #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  dds_phase_acc #(.TW_W(TW_W), .ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .adv   (acc_adv),
    .clr   (acc_clr),
    .tw    (tune_word),
    .phase (phase)
  );

  assign sign_b   = phase[PH_W-1];
  assign quad_b   = phase[PH_W-2];
  assign idx      = phase[IDX_W-1:0];
  assign rom_addr = quad_b ? ~idx : idx;

  dds_quarter_rom #(.IDX_W(IDX_W), .MAG_W(MAG_W)) u_rom (
    .clk  (clk),
    .addr (rom_addr),
    .q    (rom_q)
  );

  assign live_code = {sign_b, (sign_b ? ~rom_q : rom_q)};

  always_comb begin
    st_nxt     = st;
    acc_adv    = 1'b0;
    acc_clr    = 1'b0;
    force_zero = 1'b0;
    cap_sign   = 1'b0;
    if (tick) begin
      case (st)
        ST_RUN: begin
          acc_adv = 1'b1;
          if (inh_req) begin
            st_nxt   = ST_DRAIN;
            cap_sign = 1'b1;
          end
        end
        ST_DRAIN: begin
          if (!inh_req) begin
            acc_adv = 1'b1;
            st_nxt  = ST_RUN;
          end else if (sign_b != dsign) begin
            acc_clr    = 1'b1;
            force_zero = 1'b1;
            st_nxt     = ST_HOLD;
          end else begin
            acc_adv = 1'b1;
          end
        end
        ST_HOLD: begin
          if (inh_req) begin
            acc_clr    = 1'b1;
            force_zero = 1'b1;
          end else begin
            acc_adv = 1'b1;
            st_nxt  = ST_RUN;
          end
        end
        default: st_nxt = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_RUN;
      dsign     <= 1'b0;
      dac_code  <= '0;
      dac_valid <= 1'b0;
    end else begin
      st        <= st_nxt;
      dac_valid <= tick;
      if (cap_sign) dsign <= sign_b;
      if (pdn_req)   dac_code <= '0;
      else if (tick) dac_code <= force_zero ? '0 : live_code;
    end
  end

  // R1
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dac_valid |=> !dac_valid);

  // R9
  pdn_zero_chk: assert property (@(posedge clk) disable iff (rst)
    pdn_req |=> (dac_code == '0));

  // R6
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !pdn_req) |=> $stable(dac_code));

  // R8
  hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (dac_valid && st == ST_HOLD) |-> (dac_code == '0));

endmodule

// File: tb/dds_sine_core_tb.sv
`timescale 1ns/1ps
module dds_sine_core_tb;
  localparam int    ACC_W = 21;
  localparam real   PI    = 3.14159265358979;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] tune;
  logic        pdn;
  logic        inh;
  logic [7:0]  code;
  logic        valid;

  always #2.5 clk = ~clk;

  dds_sine_core u_dut (
    .clk       (clk),
    .rst       (rst),
    .tune_word (tune),
    .pdn_req   (pdn),
    .inh_req   (inh),
    .dac_code  (code),
    .dac_valid (valid)
  );

  int              n_vec = 0;
  int              n_bad = 0;
  int              bc    = 0;
  logic [ACC_W-1:0] macc;
  int              mst;
  logic            mds;
  logic [7:0]      exp_code;
  string           sect;

  function automatic logic [7:0] code_of(logic [8:0] p);
    int a;
    int m;
    a = p[7] ? (127 - int'(p[6:0])) : int'(p[6:0]);
    m = $rtoi(127.0 * $sin((real'(a) + 0.5) * PI / 256.0) + 0.5);
    return p[8] ? {1'b1, ~7'(m)} : {1'b0, 7'(m)};
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_tick();
    logic [7:0] live;
    logic [7:0] o;
    live = code_of(macc[ACC_W-1:ACC_W-9]);
    o = live;
    case (mst)
      0: begin
        if (inh) begin mst = 1; mds = macc[ACC_W-1]; end
        macc = macc + ACC_W'(tune);
      end
      1: begin
        if (!inh) begin macc = macc + ACC_W'(tune); mst = 0; end
        else if (macc[ACC_W-1] != mds) begin o = 8'h00; macc = '0; mst = 2; end
        else macc = macc + ACC_W'(tune);
      end
      default: begin
        if (inh) begin o = 8'h00; macc = '0; end
        else begin macc = macc + ACC_W'(tune); mst = 0; end
      end
    endcase
    exp_code = pdn ? 8'h00 : o;
  endtask

  // One clock: check the effect of the edge just passed, inputs still as sampled.
  task automatic cycle();
    logic ev;
    @(negedge clk);
    bc++;
    ev = (bc % 4 == 0);
    if (ev) model_tick();
    else if (pdn) exp_code = 8'h00;
    chk("R1", {7'b0, valid}, {7'b0, ev});
    chk(ev ? sect : (pdn ? "R9" : "R6"), code, exp_code);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", code, 8'h00);
    chk("R10", {7'b0, valid}, 8'h00);
    rst = 1'b0;
    bc = 0; macc = '0; mst = 0; mds = 1'b0; exp_code = 8'h00;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog expired got=running exp=done");
    finish_run();
  end

  initial begin
    int s;
    void'($urandom(32'h5eed_2036));
    tune = 16'd4096; pdn = 1'b0; inh = 1'b0; sect = "R4";
    do_reset();

    // R3/R4/R5 sweep: one table point per update
    s = 0;
    while (s < 512) begin
      cycle();
      if (valid) begin
        if (s == 0)   chk("R4", code, 8'h01);
        if (s == 127) chk("R4", code, 8'h7F);
        if (s == 128) chk("R3", code, 8'h7F);
        if (s == 256) chk("R5", code, 8'hFE);
        if (s == 383) chk("R5", code, 8'h80);
        s++;
      end
    end

    // R7/R8 inhibit mid half cycle
    do_reset();
    tune = 16'h4000; sect = "R7";
    repeat (90) cycle();
    inh = 1'b1;
    repeat (700) cycle();
    chk("R7", code, 8'h00);
    chk("R7", 8'(mst), 8'd2);
    inh = 1'b0; sect = "R8";
    cycle();
    while (!valid) cycle();
    chk("R8", code, 8'h01);
    repeat (40) cycle();

    // R9 power-down between strobes
    sect = "R9";
    pdn = 1'b1;
    cycle();
    chk("R9", code, 8'h00);
    repeat (21) cycle();
    pdn = 1'b0;
    repeat (30) cycle();

    // R10 mid-run reset
    do_reset();
    chk("R10", code, 8'h00);

    // R2 random tuning words with sporadic requests
    sect = "R2";
    for (int i = 0; i < 30000; i++) begin
      if (i % 600 == 0) tune = 16'($urandom);
      if (i % 5000 == 4999) tune = 16'hFFFF;
      if ($urandom % 113 == 0) pdn = ~pdn;
      if ($urandom % 409 == 0) inh = ~inh;
      cycle();
    end
    pdn = 1'b0; inh = 1'b0;
    repeat (20) cycle();
    finish_run();
  end

endmodule